// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Access Sequencer

This block turns a one-cycle command into a complete two-wire bus transaction towards a serial EEPROM. A command is either a single-byte store (word address plus one data byte) or a random fetch (word address, one data byte returned). The block drives the clock line as a push-pull output and pulls the data line low through an open-drain enable. It samples the data line through a separate input.

Each bus bit is split into four quarter-phases of `QTR_CYC` system clocks. The data line moves only in the first quarter, while the clock is low. Every slave acknowledge is checked. A missing acknowledge aborts the transfer with a STOP and an error flag. After a successful store, the block stays busy for `WAIT_CYC` cycles so that the device can finish its internal programming before the next command is accepted.

Top module: `eeprom_i2c_seq`

## Requirements
- R1: During address and data bits the data line changes only while SCL is low. The only data-line edges while SCL is high are the START (falling) and the STOP (rising).
- R2: The first byte of every addressing phase is the device code 1010 in bits 7..4, the 3-bit chip select `req_chip` in bits 3..1, and the direction in bit 0 (0 = store, 1 = fetch). All bytes are sent MSB first.
- R3: A store runs START, control byte (direction 0), word address, data byte, STOP. `done` is a single-cycle pulse.
- R4: A fetch runs START, control byte (direction 0), word address, then a repeated START with no STOP before it. It continues with the control byte (direction 1) and eight data bits read MSB first. The byte appears on `rd_data` when `done` pulses.
- R5: On the ninth clock after the fetched byte, the block leaves SDA released (no acknowledge). It then sends STOP, and `done` follows `QTR_CYC` cycles after the STOP's data-line rise.
- R6: The acknowledge is sampled while SCL is high on the ninth clock. A high level there ends the transfer at once with a STOP. The block then pulses `done` with `nack_err` = 1 and no programming wait. `nack_err` stays valid until the next accepted command, and a successful command leaves it at 0.
- R7: After a successful store, `done` is raised `QTR_CYC + WAIT_CYC` cycles after the STOP's data-line rise, and `busy` stays high until then.
- R8: Inside a transaction every SCL high phase and every SCL low phase lasts exactly `2*QTR_CYC` system clocks.
- R9: After reset, and whenever idle, SCL is high, SDA is released, and `busy` and `done` are low.
- R10: A `req_valid` raised while `busy` is high is ignored and starts no transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Command strobe, taken only while idle |
| req_read | input | 1 | 1 = random fetch, 0 = single-byte store |
| req_chip | input | 3 | Chip select bits placed in the control byte |
| req_addr | input | 8 | Word address inside the device |
| req_wdata | input | 8 | Byte to store |
| busy | output | 1 | Transaction or programming wait in progress |
| done | output | 1 | One-cycle completion pulse |
| nack_err | output | 1 | Last command lost an acknowledge |
| rd_data | output | 8 | Byte returned by the last fetch |
| scl | output | 1 | Bus clock line |
| sda_oe | output | 1 | 1 pulls the data line low, 0 releases it |
| sda_in | input | 1 | Sampled level of the data line |

## Verification
A behavioural EEPROM on the bench decodes the bus and answers only to its own chip select. Stores and fetches use the data values 0x55, 0xA3 and 0x0F, which have alternating, inverted and split bit patterns, so a swapped shift order or a dropped bit gives a different byte. A preloaded location is fetched without a prior store, which shows the returned byte comes from the bus and not from a stale register. A wrong chip select separates the abort path from the store path by the number of bytes seen, the error flag and the absence of the programming wait. A command issued in the middle of a store shows whether it leaks into an extra START.

// File: rtl/eeprom_i2c_pkg.sv
package eeprom_i2c_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_START,
      ST_BIT,
      ST_STOP,
      ST_HOLD
   } seq_state_t;

   localparam logic [3:0] DEV_CODE  = 4'b1010;
   localparam int         BYTE_W    = 8;
   localparam int         CHIP_W    = 3;
   localparam logic [3:0] ACK_SLOT  = 4'd8;

endpackage

// File: rtl/eeprom_i2c_tick.sv
module eeprom_i2c_tick #(
   parameter int QTR_CYC = 125
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   output logic tick
);
   localparam int CW = (QTR_CYC > 1) ? $clog2(QTR_CYC) : 1;

   generate
      if (QTR_CYC < 1) begin : g_bad_qtr
         $error("QTR_CYC must be at least 1");
      end

      if (QTR_CYC == 1) begin : g_every
         assign tick = en;
      end else begin : g_div
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cnt <= '0;
            else if (!en)                        cnt <= '0;
            else if (cnt == CW'(QTR_CYC - 1))    cnt <= '0;
            else                                 cnt <= cnt + 1'b1;
         end
         assign tick = en && (cnt == CW'(QTR_CYC - 1));
      end
   endgenerate
endmodule

// File: rtl/eeprom_i2c_hold.sv
module eeprom_i2c_hold #(
   parameter int WAIT_CYC = 500000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic expire
);
   localparam int WW = (WAIT_CYC > 1) ? $clog2(WAIT_CYC) : 1;

   generate
      if (WAIT_CYC < 0) begin : g_bad_wait
         $error("WAIT_CYC must not be negative");
      end

      if (WAIT_CYC <= 1) begin : g_short
         assign expire = 1'b1;
      end else begin : g_cnt
         logic          act;
         logic [WW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act <= 1'b0;
               cnt <= '0;
            end else if (start) begin
               act <= 1'b1;
               cnt <= WW'(WAIT_CYC - 1);
            end else if (act) begin
               if (cnt == '0) act <= 1'b0;
               else           cnt <= cnt - 1'b1;
            end
         end
         assign expire = act && (cnt == '0);

         AST_HOLD_NO_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
            act |-> !start); // R7
      end
   endgenerate
endmodule

// File: rtl/eeprom_i2c_seq.sv
module eeprom_i2c_seq
   import eeprom_i2c_pkg::*;
#(
   parameter int QTR_CYC  = 125,
   parameter int WAIT_CYC = 500000
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                req_valid,
   input  logic                req_read,
   input  logic [CHIP_W-1:0]   req_chip,
   input  logic [BYTE_W-1:0]   req_addr,
   input  logic [BYTE_W-1:0]   req_wdata,
   output logic                busy,
   output logic                done,
   output logic                nack_err,
   output logic [BYTE_W-1:0]   rd_data,
   output logic                scl,
   output logic                sda_oe,
   input  logic                sda_in
);
   seq_state_t          state;
   logic [1:0]          ph;
   logic [3:0]          bitn;
   logic [1:0]          byten;
   logic [BYTE_W-1:0]   sh, rx, rdata_q;
   logic [BYTE_W-1:0]   addr_q, wdata_q;
   logic [CHIP_W-1:0]   chip_q;
   logic                rd_q, nack_q, scl_q, sda_oe_q, done_q, err_q;
   logic                tick, seq_run, is_rx, hold_go, hold_done;

   function automatic logic [BYTE_W-1:0] slot_byte(
      input logic [1:0]        idx,
      input logic              rd,
      input logic [CHIP_W-1:0] chip,
      input logic [BYTE_W-1:0] addr,
      input logic [BYTE_W-1:0] wdata);
      case (idx)
         2'd0:    slot_byte = {DEV_CODE, chip, 1'b0};
         2'd1:    slot_byte = addr;
         2'd2:    slot_byte = rd ? {DEV_CODE, chip, 1'b1} : wdata;
         default: slot_byte = '0;
      endcase
   endfunction

   assign seq_run = (state == ST_START) || (state == ST_BIT) || (state == ST_STOP);
   assign is_rx   = rd_q && (byten == 2'd3);
   assign hold_go = (state == ST_STOP) && tick && (ph == 2'd3) && !nack_q && !rd_q;

   eeprom_i2c_tick #(.QTR_CYC(QTR_CYC)) u_tick (
      .clk(clk), .rst_n(rst_n), .en(seq_run), .tick(tick));

   eeprom_i2c_hold #(.WAIT_CYC(WAIT_CYC)) u_hold (
      .clk(clk), .rst_n(rst_n), .start(hold_go), .expire(hold_done));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_IDLE;
         ph       <= '0;
         bitn     <= '0;
         byten    <= '0;
         sh       <= '0;
         rx       <= '0;
         rdata_q  <= '0;
         addr_q   <= '0;
         wdata_q  <= '0;
         chip_q   <= '0;
         rd_q     <= 1'b0;
         nack_q   <= 1'b0;
         scl_q    <= 1'b1;
         sda_oe_q <= 1'b0;
         done_q   <= 1'b0;
         err_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  rd_q    <= req_read;
                  chip_q  <= req_chip;
                  addr_q  <= req_addr;
                  wdata_q <= req_wdata;
                  byten   <= 2'd0;
                  ph      <= 2'd0;
                  nack_q  <= 1'b0;
                  err_q   <= 1'b0;
                  state   <= ST_START;
               end
            end
            ST_START: begin
               if (tick) begin
                  ph <= ph + 2'd1;
                  case (ph)
                     2'd0: sda_oe_q <= 1'b0;
                     2'd1: scl_q    <= 1'b1;
                     2'd2: sda_oe_q <= 1'b1;
                     default: begin
                        scl_q <= 1'b0;
                        bitn  <= '0;
                        sh    <= slot_byte(byten, rd_q, chip_q, addr_q, wdata_q);
                        state <= ST_BIT;
                     end
                  endcase
               end
            end
            ST_BIT: begin
               if (tick) begin
                  ph <= ph + 2'd1;
                  case (ph)
                     2'd0: sda_oe_q <= (bitn == ACK_SLOT || is_rx) ? 1'b0 : ~sh[BYTE_W-1];
                     2'd1: scl_q <= 1'b1;
                     2'd2: begin
                        if (bitn != ACK_SLOT) begin
                           sh <= {sh[BYTE_W-2:0], 1'b0};
                           if (is_rx) rx <= {rx[BYTE_W-2:0], sda_in};
                        end else if (!is_rx && sda_in) begin
                           nack_q <= 1'b1;
                        end
                     end
                     default: begin
                        scl_q <= 1'b0;
                        if (bitn != ACK_SLOT) begin
                           bitn <= bitn + 4'd1;
                        end else if (nack_q || is_rx || (!rd_q && byten == 2'd2)) begin
                           state <= ST_STOP;
                        end else if (rd_q && byten == 2'd1) begin
                           byten <= 2'd2;
                           state <= ST_START;
                        end else begin
                           byten <= byten + 2'd1;
                           bitn  <= '0;
                           sh    <= slot_byte(byten + 2'd1, rd_q, chip_q, addr_q, wdata_q);
                        end
                     end
                  endcase
               end
            end
            ST_STOP: begin
               if (tick) begin
                  ph <= ph + 2'd1;
                  case (ph)
                     2'd0: sda_oe_q <= 1'b1;
                     2'd1: scl_q    <= 1'b1;
                     2'd2: sda_oe_q <= 1'b0;
                     default: begin
                        if (!nack_q && !rd_q) begin
                           state <= ST_HOLD;
                        end else begin
                           state  <= ST_IDLE;
                           done_q <= 1'b1;
                           err_q  <= nack_q;
                           if (rd_q && !nack_q) rdata_q <= rx;
                        end
                     end
                  endcase
               end
            end
            ST_HOLD: begin
               if (hold_done) begin
                  state  <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign done     = done_q;
   assign nack_err = err_q;
   assign rd_data  = rdata_q;
   assign scl      = scl_q;
   assign sda_oe   = sda_oe_q;

   AST_SDA_STEADY_CLK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BIT && scl_q && $past(scl_q)) |-> $stable(sda_oe_q)); // R1
   AST_IDLE_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_IDLE) |-> (scl_q && !sda_oe_q)); // R9
   AST_ACK_SLOT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_BIT && bitn == ACK_SLOT && scl_q) |-> !sda_oe_q); // R5
   AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err_q) |-> done_q); // R6
   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_q |=> !done_q); // R3
endmodule

// File: tb/eeprom_i2c_seq_test.sv
module eeprom_i2c_seq_test;
   localparam int QTR  = 4;
   localparam int WAIT = 300;
   localparam logic [2:0] SL_CHIP = 3'b010;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_read = 1'b0;
   logic [2:0] req_chip = '0;
   logic [7:0] req_addr = '0, req_wdata = '0;
   logic busy, done, nack_err, scl, sda_oe;
   logic [7:0] rd_data;
   logic s_drv = 1'b0;
   wire  sda_bus = !(sda_oe || s_drv);

   int compared = 0, mismatched = 0, cyc = 0;
   bit armed = 0;

   eeprom_i2c_seq #(.QTR_CYC(QTR), .WAIT_CYC(WAIT)) uut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_read(req_read),
      .req_chip(req_chip), .req_addr(req_addr), .req_wdata(req_wdata),
      .busy(busy), .done(done), .nack_err(nack_err), .rd_data(rd_data),
      .scl(scl), .sda_oe(sda_oe), .sda_in(sda_bus));

   always #10 clk = ~clk;
   always @(posedge clk) cyc++;

   // behavioural EEPROM
   logic [7:0] mem [0:255];
   logic [7:0] rxlog [0:7];
   logic [7:0] sr, tx, ptr;
   int rxn = 0, bc = 0, bno = 0, rbit = 0;
   int n_start = 0, n_stop = 0, n_rstart = 0, stop_cyc = 0;
   bit in_txn = 0, act = 0, rw = 0, reading = 0, mack = 0;
   bit hcand = 0, lcand = 0;

   always @(negedge sda_bus) if (armed && scl === 1'b1) begin
      n_start++;
      if (in_txn) n_rstart++;
      in_txn = 1; bc = 0; bno = 0; reading = 0; act = 0; s_drv = 0;
   end

   always @(posedge sda_bus) if (armed && scl === 1'b1) begin
      n_stop++; in_txn = 0; reading = 0; s_drv = 0; stop_cyc = cyc; hcand = 0;
   end

   always @(posedge scl) if (armed && in_txn) begin
      if (reading) begin
         if (rbit == 8) mack = sda_bus;
         rbit++;
      end else begin
         if (bc < 8) sr = {sr[6:0], sda_bus};
         bc++;
      end
   end

   always @(negedge scl) if (armed && in_txn) begin
      if (reading) begin
         if (rbit < 8) s_drv = !tx[7-rbit];
         else          s_drv = 0;
      end else if (bc == 8) begin
         if (rxn < 8) rxlog[rxn] = sr;
         rxn++;
         if (bno == 0) begin
            act = (sr[7:1] == {4'b1010, SL_CHIP});
            rw  = sr[0];
         end else if (act && !rw) begin
            if (bno == 1) ptr = sr;
            else          mem[ptr] = sr;
         end
         s_drv = act;
      end else if (bc == 9) begin
         s_drv = 0; bc = 0; bno++;
         if (act && rw) begin
            reading = 1; rbit = 0; tx = mem[ptr]; s_drv = !tx[7];
         end
      end
   end

   // bus-level monitor for R1 and R8
   logic pscl = 1'b1, psda = 1'b1;
   int hrun = 0, lrun = 0, hi_chg = 0;
   int hmin = 1000000, hmax = 0, lmin = 1000000, lmax = 0;
   always @(posedge clk) if (armed) begin
      if (pscl && scl && (psda !== sda_bus)) hi_chg++;
      if (scl && !pscl) begin
         if (lcand) begin
            if (lrun < lmin) lmin = lrun;
            if (lrun > lmax) lmax = lrun;
         end
         hrun = 0; hcand = in_txn;
      end
      if (!scl && pscl) begin
         if (hcand) begin
            if (hrun < hmin) hmin = hrun;
            if (hrun > hmax) hmax = hrun;
         end
         lrun = 0; lcand = in_txn;
      end
      if (scl) hrun++; else lrun++;
      pscl = scl; psda = sda_bus;
   end

   task automatic chk(input bit ok, input string tag, input int actv, input int expv);
      compared++;
      if (!ok) begin
         mismatched++;
         $display("FAIL %s actual %0d expected %0d", tag, actv, expv);
      end
   endtask

   task automatic issue(input bit rd, input logic [2:0] ch, input logic [7:0] a, input logic [7:0] d);
      @(negedge clk);
      while (busy) @(negedge clk);
      req_valid = 1; req_read = rd; req_chip = ch; req_addr = a; req_wdata = d;
      @(negedge clk);
      req_valid = 0;
   endtask

   task automatic wait_done(output int at);
      while (done !== 1'b1) @(negedge clk);
      at = cyc;
   endtask

   task automatic t_reset;
      chk(scl === 1'b1, "R9 scl", int'(scl), 1);
      chk(sda_oe === 1'b0, "R9 sda_oe", int'(sda_oe), 0);
      chk(busy === 1'b0, "R9 busy", int'(busy), 0);
      chk(done === 1'b0, "R9 done", int'(done), 0);
   endtask

   task automatic t_write(input logic [7:0] a, input logic [7:0] d);
      int s0, p0, at;
      s0 = n_start; p0 = n_stop; rxn = 0;
      issue(0, SL_CHIP, a, d);
      wait_done(at);
      chk(rxn == 3, "R3 byte count", rxn, 3);
      chk(rxlog[0] == 8'hA4, "R2 control W", int'(rxlog[0]), 'hA4);
      chk(rxlog[1] == a, "R3 word address", int'(rxlog[1]), int'(a));
      chk(rxlog[2] == d, "R3 data byte", int'(rxlog[2]), int'(d));
      chk(mem[a] == d, "R3 stored", int'(mem[a]), int'(d));
      chk(n_start - s0 == 1 && n_stop - p0 == 1, "R3 start/stop", n_stop - p0, 1);
      chk(nack_err == 1'b0, "R6 no error", int'(nack_err), 0);
      chk(at - stop_cyc == QTR + WAIT, "R7 write wait", at - stop_cyc, QTR + WAIT);
   endtask

   task automatic t_read(input logic [7:0] a, input logic [7:0] e);
      int r0, p0, at;
      r0 = n_rstart; p0 = n_stop; rxn = 0; mack = 0;
      issue(1, SL_CHIP, a, 8'h00);
      wait_done(at);
      chk(rd_data == e, "R4 read data", int'(rd_data), int'(e));
      chk(rxn == 3 && rxlog[2] == 8'hA5, "R2 control R", int'(rxlog[2]), 'hA5);
      chk(n_rstart - r0 == 1, "R4 repeated start", n_rstart - r0, 1);
      chk(n_stop - p0 == 1, "R4 single stop", n_stop - p0, 1);
      chk(mack == 1'b1, "R5 master no-ack", int'(mack), 1);
      chk(at - stop_cyc == QTR, "R5 done after stop", at - stop_cyc, QTR);
      chk(nack_err == 1'b0, "R6 error cleared", int'(nack_err), 0);
   endtask

   task automatic t_nack(input logic [7:0] a);
      int p0, at;
      logic [7:0] old;
      old = mem[a]; p0 = n_stop; rxn = 0;
      issue(0, 3'b101, a, 8'hEE);
      wait_done(at);
      chk(nack_err == 1'b1, "R6 error flag", int'(nack_err), 1);
      chk(rxn == 1, "R6 abort after control", rxn, 1);
      chk(n_stop - p0 == 1, "R6 stop sent", n_stop - p0, 1);
      chk(at - stop_cyc == QTR, "R6 no wait", at - stop_cyc, QTR);
      chk(mem[a] == old, "R6 memory untouched", int'(mem[a]), int'(old));
   endtask

   task automatic t_ignore;
      int s0, at;
      s0 = n_start;
      issue(0, SL_CHIP, 8'h20, 8'h3C);
      repeat (20) @(negedge clk);
      req_valid = 1; req_read = 1; req_addr = 8'h20; req_chip = SL_CHIP;
      @(negedge clk);
      req_valid = 0;
      wait_done(at);
      repeat (40) @(negedge clk);
      chk(busy == 1'b0, "R10 stays idle", int'(busy), 0);
      chk(n_start - s0 == 1, "R10 single start", n_start - s0, 1);
      chk(mem[8'h20] == 8'h3C, "R10 store intact", int'(mem[8'h20]), 'h3C);
   endtask

   task automatic t_timing;
      chk(hmin == 2*QTR && hmax == 2*QTR, "R8 scl high", hmax, 2*QTR);
      chk(lmin == 2*QTR && lmax == 2*QTR, "R8 scl low", lmax, 2*QTR);
      chk(hi_chg == n_start + n_stop, "R1 sda edges with scl high", hi_chg, n_start + n_stop);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 8'h00;
      mem[8'h41] = 8'h0F;
      repeat (4) @(posedge clk);
      rst_n = 1;
      @(negedge clk);
      armed = 1;
      t_reset();
      t_write(8'h03, 8'h55);
      t_read(8'h03, 8'h55);
      t_write(8'h80, 8'hA3);
      t_read(8'h80, 8'hA3);
      t_read(8'h41, 8'h0F);
      t_nack(8'h03);
      t_read(8'h03, 8'h55);
      t_ignore();
      t_timing();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      compared++; mismatched++;
      $display("FAIL watchdog actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule